// File: doc/BRIEF.md
# Configuration Request Packer

This block turns one configuration access request (read or write, target bus, device/function, byte offset, access size and write data) into a three-doubleword configuration request header. It hands the header and data out as a short train of 64-bit beats, each beat made of two 32-bit words, marked with start and end flags. Both the request input and the beat output use a valid/ready handshake. Only one packet is in flight at a time.

The block keeps its own copy of the root bus number. A request whose target bus matches this number is sent as a Type 0 access; any other bus gets a Type 1 access. Once a write to the root bus's primary bus number register has fully left the block, the copy takes the new value. Where the write data sits among the beats depends on whether the offset is aligned to a quadword.

Top module: `cfg_tlp_packer`

## Requirements
- R1: `req_ready` is high exactly when no packet is in progress; a request is taken on a clock edge where `req_valid` and `req_ready` are both high, its first beat is valid from the next cycle, and `req_ready` stays low until the cycle after the final beat has been taken.
- R2: Header word 0 carries a format/type byte in bits 31:24 (0x04 read, 0x44 write when the target bus equals the root bus number; 0x05 read, 0x45 write otherwise), the value 1 in bits 9:0 and zero elsewhere.
- R3: Header word 1 carries the requester ID in bits 31:16 (root bus number in 31:24, zero in 23:16), the tag in bits 15:8 (0x1D for reads, 0x10 for writes) and the byte enables in bits 7:0.
- R4: Header word 2 carries the target bus in bits 31:24, the device/function in bits 23:16 and the offset with bits 1:0 cleared in bits 15:0.
- R5: With `req_size` 0 (one byte) the byte enables are 0x01 shifted left by offset[1:0]; with 1 (two bytes) 0x03 shifted left by offset[1:0]; with 2 or 3 (four bytes) 0x0F.
- R6: Write data is cut to its low 1, 2 or 4 bytes according to `req_size` and shifted left by 8 times offset[1:0], truncated to 32 bits; reads carry zero data.
- R7: The first beat carries header word 0 in `beat_data[31:0]`, header word 1 in `beat_data[63:32]`, with `beat_sop` high and `beat_eop` low.
- R8: For a read, or a write whose offset[2:0] is not zero, the second and last beat carries header word 2 in the low word and the data word in the high word, with `beat_eop` high and `beat_sop` low.
- R9: For a write with offset[2:0] equal to zero, the second beat carries header word 2 and zero with both flags low, and the third beat carries the data word in the low word and zero in the high word with `beat_eop` high.
- R10: While `beat_valid` is high and `beat_ready` is low, the beat data and flags hold their values and `beat_valid` stays high.
- R11: The root bus number is 0 after reset; it changes only when the final beat of a write to the root bus whose offset with bits 1:0 cleared is 0x18 is taken, and then takes bits 7:0 of that write's shifted data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_offset | input | 12 | Byte offset into configuration space |
| req_size | input | 2 | Access size: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| req_wdata | input | 32 | Write value, right-aligned |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_data | output | 64 | Beat: first word in bits 31:0, second in 63:32 |
| beat_sop | output | 1 | First beat of a packet |
| beat_eop | output | 1 | Last beat of a packet |

## Verification
The first beat is due one cycle after the edge that takes a request, each later beat one cycle after the edge that takes the previous one, and `req_ready` returns one cycle after the edge that takes the last beat. A root bus update becomes visible in the headers of the next accepted request. The bench's reference model applies the handshakes of each edge to a queue of expected beats and compares ports against its head half a period after every edge, so each result is checked in exactly the cycle it is due, including cycles held by a stalled consumer.

// File: rtl/cfg_tlp_pkg.sv
// Shared constants and types for the configuration request packer.
// Assumes 32-bit header words and 8-bit bus and device/function fields.
package cfg_tlp_pkg;
    localparam int WORD_W  = 32;
    localparam int BEAT_W  = 2 * WORD_W;
    localparam int BUS_W   = 8;
    localparam int DEVFN_W = 8;
    localparam int LANES   = WORD_W / 8;

    localparam logic [7:0] FMT_RD_LOCAL  = 8'h04;
    localparam logic [7:0] FMT_WR_LOCAL  = 8'h44;
    localparam logic [7:0] FMT_RD_REMOTE = 8'h05;
    localparam logic [7:0] FMT_WR_REMOTE = 8'h45;
    localparam logic [7:0] TAG_RD        = 8'h1D;
    localparam logic [7:0] TAG_WR        = 8'h10;

    // Fully formed packet contents held while beats go out.
    typedef struct packed {
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w2;
        logic [WORD_W-1:0] data;
        logic              aligned_wr;
        logic              root_upd;
    } pkt_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HDR  = 2'd1,
        SQ_MID  = 2'd2,
        SQ_LAST = 2'd3
    } seq_state_t;
endpackage

// File: rtl/cfg_hdr_build.sv
// Combinational header former: computes the three header words, the
// positioned write data and the packet-shape flags from one request and
// the current root bus number. Assumes OFS_W is between 3 and 16.
module cfg_hdr_build
    import cfg_tlp_pkg::*;
#(
    parameter int OFS_W   = 12,
    parameter int PRI_OFS = 24
) (
    input  logic               is_write,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [1:0]         size,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [BUS_W-1:0]   root,
    output pkt_t               pkt
);
    logic [LANES-1:0]  keep;
    logic [WORD_W-1:0] masked;
    logic [WORD_W-1:0] shifted;
    logic [7:0]        be;
    logic [7:0]        fmt;
    logic [OFS_W-1:0]  ofs_al;
    logic              local_bus;

    // Per-lane keep mask and masking of the write value by access size.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign keep[i] = (i == 0) || ((i < 2) && (size == 2'd1)) || size[1];
        assign masked[8*i +: 8] = keep[i] ? wdata[8*i +: 8] : 8'h00;
    end

    assign shifted   = masked << {ofs[1:0], 3'b000};
    assign ofs_al    = {ofs[OFS_W-1:2], 2'b00};
    assign local_bus = (bus == root);

    // Byte-enable pattern from access size and low offset bits.
    always_comb begin
        case (size)
            2'd0:    be = 8'h01 << ofs[1:0];
            2'd1:    be = 8'h03 << ofs[1:0];
            default: be = 8'h0F;
        endcase
    end

    // Format/type selection between local and remote, read and write.
    always_comb begin
        if (is_write) fmt = local_bus ? FMT_WR_LOCAL : FMT_WR_REMOTE;
        else          fmt = local_bus ? FMT_RD_LOCAL : FMT_RD_REMOTE;
    end

    // Assemble the packet record.
    always_comb begin
        pkt.w0         = {fmt, 14'h0000, 10'd1};
        pkt.w1         = {root, 8'h00, (is_write ? TAG_WR : TAG_RD), be};
        pkt.w2         = {bus, devfn, 16'(ofs_al)};
        pkt.data       = is_write ? shifted : '0;
        pkt.aligned_wr = is_write && (ofs[2:0] == 3'd0);
        pkt.root_upd   = is_write && local_bus && (ofs_al == OFS_W'(PRI_OFS));
    end
endmodule

// File: rtl/cfg_root_bus_reg.sv
// Root bus number register: resets to zero and loads a new value on an
// update strobe. Assumes the strobe lasts a single cycle.
module cfg_root_bus_reg
    import cfg_tlp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [BUS_W-1:0] val,
    output logic [BUS_W-1:0] root
);
    // Hold or load the root bus number.
    always_ff @(posedge clk) begin
        if (!rst_n)   root <= '0;
        else if (upd) root <= val;
    end
endmodule

// File: rtl/cfg_beat_seq.sv
// Beat sequencer: stores a packet record when a request is taken and
// walks it out as two or three beats. Beat content is a function of the
// state and the stored record only, so it cannot move during a stall.
module cfg_beat_seq
    import cfg_tlp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  pkt_t              pkt_in,
    input  logic              beat_ready,
    output logic              beat_valid,
    output logic [BEAT_W-1:0] beat_data,
    output logic              beat_sop,
    output logic              beat_eop,
    output logic              idle,
    output logic              root_upd,
    output logic [BUS_W-1:0]  root_val
);
    seq_state_t state;
    pkt_t       pkt_q;
    logic       fire;

    assign fire       = beat_valid && beat_ready;
    assign beat_valid = (state != SQ_IDLE);
    assign idle       = (state == SQ_IDLE);

    // Capture the packet record on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)    pkt_q <= '0;
        else if (take) pkt_q <= pkt_in;
    end

    // Advance through the beats as each one is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            case (state)
                SQ_IDLE: if (take) state <= SQ_HDR;
                SQ_HDR:  if (fire) state <= pkt_q.aligned_wr ? SQ_MID : SQ_LAST;
                SQ_MID:  if (fire) state <= SQ_LAST;
                default: if (fire) state <= SQ_IDLE;
            endcase
        end
    end

    // Beat contents and flags for the current state.
    always_comb begin
        beat_data = '0;
        beat_sop  = 1'b0;
        beat_eop  = 1'b0;
        case (state)
            SQ_HDR: begin
                beat_data = {pkt_q.w1, pkt_q.w0};
                beat_sop  = 1'b1;
            end
            SQ_MID: beat_data = {{WORD_W{1'b0}}, pkt_q.w2};
            SQ_LAST: begin
                beat_data = pkt_q.aligned_wr ? {{WORD_W{1'b0}}, pkt_q.data}
                                             : {pkt_q.data, pkt_q.w2};
                beat_eop  = 1'b1;
            end
            default: ;
        endcase
    end

    assign root_upd = fire && beat_eop && pkt_q.root_upd;
    assign root_val = pkt_q.data[BUS_W-1:0];

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_data)
        && $stable(beat_sop) && $stable(beat_eop)); // R10
    AST_TAKE_GIVES_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> beat_valid && beat_sop); // R7
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !(beat_sop && beat_eop)); // R8
    AST_EOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        fire && beat_eop |=> !beat_valid && idle); // R1
    AST_SOP_FOLLOWS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid) |-> beat_sop); // R7
endmodule

// File: rtl/cfg_tlp_packer.sv
// Configuration request packer top: takes one request at a time, forms
// the header against the tracked root bus number and emits it as beats.
// Assumes the consumer keeps beat_ready independent of beat_valid.
module cfg_tlp_packer
    import cfg_tlp_pkg::*;
#(
    parameter int OFS_W   = 12,
    parameter int PRI_OFS = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [OFS_W-1:0]   req_offset,
    input  logic [1:0]         req_size,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic               beat_valid,
    input  logic               beat_ready,
    output logic [BEAT_W-1:0]  beat_data,
    output logic               beat_sop,
    output logic               beat_eop
);
    pkt_t             pkt;
    logic [BUS_W-1:0] root_q;
    logic [BUS_W-1:0] root_new;
    logic             root_upd;
    logic             idle;
    logic             take;

    assign req_ready = idle;
    assign take      = req_valid && idle;

    cfg_hdr_build #(.OFS_W(OFS_W), .PRI_OFS(PRI_OFS)) u_hdr (
        .is_write (req_write),
        .bus      (req_bus),
        .devfn    (req_devfn),
        .ofs      (req_offset),
        .size     (req_size),
        .wdata    (req_wdata),
        .root     (root_q),
        .pkt      (pkt)
    );

    cfg_beat_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .pkt_in     (pkt),
        .beat_ready (beat_ready),
        .beat_valid (beat_valid),
        .beat_data  (beat_data),
        .beat_sop   (beat_sop),
        .beat_eop   (beat_eop),
        .idle       (idle),
        .root_upd   (root_upd),
        .root_val   (root_new)
    );

    cfg_root_bus_reg u_root (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (root_upd),
        .val   (root_new),
        .root  (root_q)
    );

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !req_ready); // R1
    AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $countones(pkt.w1[7:0]) ==
                 ((req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4)); // R5
    AST_ROOT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_valid && beat_ready && beat_eop) |=> $stable(root_q)); // R11
endmodule

// File: tb/cfg_tlp_packer_tb.sv
module cfg_tlp_packer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = 8'h00;
    logic [7:0]  req_devfn = 8'h00;
    logic [11:0] req_offset = 12'h000;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_wdata = 32'h0;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [63:0] beat_data;
    logic        beat_sop;
    logic        beat_eop;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_tlp_packer dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bus(req_bus), .req_devfn(req_devfn),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_data(beat_data), .beat_sop(beat_sop), .beat_eop(beat_eop)
    );

    // Reference model state.
    logic [65:0] exp_q[$];      // {sop, eop, data}
    int          pos_q[$];      // 0 first, 1 aligned middle, 2 last unaligned/read, 3 last aligned
    int          root_m = 0;
    bit          upd_pend = 0;
    int          upd_val = 0;
    bit          prev_stall = 0;
    logic [65:0] prev_beat;
    int          stall_pct = 25;

    // Pending request driven by step().
    bit          p_act = 0;
    bit          p_wr;
    int          p_bus, p_devfn, p_ofs, p_size;
    logic [31:0] p_data;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic compare();
        logic [65:0] e;
        logic [63:0] d;
        chk("R1 req_ready", 64'(req_ready), 64'(exp_q.size() == 0));
        chk("R1 beat_valid", 64'(beat_valid), 64'(exp_q.size() != 0));
        if (prev_stall)
            chk("R10 held beat", {beat_valid, beat_sop, beat_eop, beat_data[60:0]},
                {1'b1, prev_beat[65:64], prev_beat[60:0]});
        if (exp_q.size() != 0) begin
            e = exp_q[0];
            d = e[63:0];
            case (pos_q[0])
                0: begin
                    chk("R2 word0 fmt/type", 64'(beat_data[31:24]), 64'(d[31:24]));
                    chk("R2 word0 low", 64'(beat_data[23:0]), 64'(d[23:0]));
                    chk("R3 requester id", 64'(beat_data[63:48]), 64'(d[63:48]));
                    chk("R11 root in requester", 64'(beat_data[63:56]), 64'(root_m[7:0]));
                    chk("R3 tag", 64'(beat_data[47:40]), 64'(d[47:40]));
                    chk("R5 byte enables", 64'(beat_data[39:32]), 64'(d[39:32]));
                    chk("R7 first beat flags", {62'd0, beat_sop, beat_eop}, {62'd0, e[65:64]});
                end
                1: begin
                    chk("R4 word2", 64'(beat_data[31:0]), 64'(d[31:0]));
                    chk("R9 middle beat", {beat_sop, beat_eop, beat_data[63:32]}, 64'({e[65:64], 32'h0}));
                end
                2: begin
                    chk("R4 word2", 64'(beat_data[31:0]), 64'(d[31:0]));
                    chk("R6 data word", 64'(beat_data[63:32]), 64'(d[63:32]));
                    chk("R8 last beat flags", {62'd0, beat_sop, beat_eop}, {62'd0, e[65:64]});
                end
                default: begin
                    chk("R6 data word", 64'(beat_data[31:0]), 64'(d[31:0]));
                    chk("R9 last beat", {beat_sop, beat_eop, beat_data[63:32]}, 64'({e[65:64], 32'h0}));
                end
            endcase
        end
    endtask

    task automatic build_pkt();
        int          al;
        bit          loc;
        logic [7:0]  fmt, tag, be;
        logic [31:0] w0, w1, w2, dat, msk;
        al  = p_ofs & ~3;
        loc = (p_bus == root_m);
        fmt = p_wr ? (loc ? 8'h44 : 8'h45) : (loc ? 8'h04 : 8'h05);
        tag = p_wr ? 8'h10 : 8'h1D;
        if (p_size == 0)      begin be = 8'(1 << (p_ofs % 4)); msk = 32'hFF; end
        else if (p_size == 1) begin be = 8'(3 << (p_ofs % 4)); msk = 32'hFFFF; end
        else                  begin be = 8'h0F; msk = 32'hFFFF_FFFF; end
        dat = p_wr ? ((p_data & msk) << (8 * (p_ofs % 4))) : 32'h0;
        w0  = {fmt, 24'h1};
        w1  = {8'(root_m), 8'h00, tag, be};
        w2  = {8'(p_bus), 8'(p_devfn), 16'(al)};
        exp_q.push_back({2'b10, w1, w0}); pos_q.push_back(0);
        if (p_wr && (p_ofs % 8) == 0) begin
            exp_q.push_back({2'b00, 32'h0, w2});  pos_q.push_back(1);
            exp_q.push_back({2'b01, 32'h0, dat}); pos_q.push_back(3);
        end else begin
            exp_q.push_back({2'b01, dat, w2}); pos_q.push_back(2);
        end
        upd_pend = p_wr && loc && (al == 24);
        upd_val  = int'(dat[7:0]);
    endtask

    // One clock: compare after the previous edge, drive inputs, model the next edge.
    task automatic step();
        logic [65:0] popped;
        @(negedge clk);
        compare();
        req_valid  = p_act;
        req_write  = p_wr;
        req_bus    = 8'(p_bus);
        req_devfn  = 8'(p_devfn);
        req_offset = 12'(p_ofs);
        req_size   = 2'(p_size);
        req_wdata  = p_data;
        beat_ready = ($urandom_range(99) >= stall_pct);
        prev_stall = beat_valid && !beat_ready;
        prev_beat  = {beat_sop, beat_eop, beat_data};
        if (beat_ready && exp_q.size() != 0) begin
            popped = exp_q.pop_front();
            void'(pos_q.pop_front());
            if (popped[64] && upd_pend) begin
                root_m   = upd_val;
                upd_pend = 0;
            end
        end else if (req_valid && exp_q.size() == 0) begin
            build_pkt();
            p_act = 0;
        end
    endtask

    task automatic send(input bit wr, input int bus, input int devfn, input int ofs,
                        input int size, input logic [31:0] data);
        p_wr = wr; p_bus = bus; p_devfn = devfn; p_ofs = ofs; p_size = size; p_data = data;
        p_act = 1;
        while (p_act) step();
    endtask

    task automatic drain();
        while (exp_q.size() != 0) step();
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        p_wr = 0; p_bus = 0; p_devfn = 0; p_ofs = 0; p_size = 0; p_data = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset req_ready", 64'(req_ready), 64'd1);
        chk("R1 reset beat_valid", 64'(beat_valid), 64'd0);
        rst_n = 1'b1;
        // R11: root 0 after reset -> bus 0 is local
        send(0, 0, 8'h00, 12'h000, 2, 32'h0);
        send(0, 3, 8'h08, 12'h013, 0, 32'h0);          // R5 byte at lane 3, remote read
        send(0, 1, 8'h11, 12'h022, 1, 32'h0);          // R5 half at lane 2
        send(1, 0, 8'h00, 12'h004, 2, 32'hDEADBEEF);   // R8 unaligned write
        send(1, 2, 8'h10, 12'h010, 2, 32'h12345678);   // R9 aligned write, remote
        send(1, 0, 8'h00, 12'h01B, 0, 32'hFFFFFFA5);   // R6 byte shift; R11 update with 0x00
        send(1, 0, 8'h00, 12'h01A, 1, 32'hAAAA5555);   // R6 half shift
        send(1, 0, 8'h00, 12'h018, 2, 32'h00000507);   // R11 root becomes 7
        send(0, 7, 8'h00, 12'h010, 2, 32'h0);          // now local
        send(0, 0, 8'h00, 12'h010, 2, 32'h0);          // now remote
        send(1, 7, 8'h00, 12'h019, 0, 32'h00000033);   // R11 root 0 via shifted low byte
        send(1, 3, 8'h00, 12'h018, 2, 32'h00000009);   // remote: no update
        send(0, 0, 8'h00, 12'h000, 2, 32'h0);
        drain();
        stall_pct = 70;                                // R10 heavy stalls
        for (int i = 0; i < 300; i++)
            send($urandom_range(1), $urandom_range(3), $urandom_range(255),
                 $urandom_range(4095), $urandom_range(3), $urandom());
        stall_pct = 0;                                 // R1 back-to-back
        for (int i = 0; i < 200; i++)
            send($urandom_range(1), $urandom_range(1) ? root_m : $urandom_range(255),
                 $urandom_range(255), $urandom_range(1) ? 24 : $urandom_range(4095),
                 $urandom_range(3), $urandom());
        drain();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule